// File: doc/BRIEF.md
# Status Register Control Unit

This unit owns a 16-bit processor status register. The low byte carries the condition flags. The high byte carries the supervisor bit and the interrupt mask. The unit carries out four operations on the register: a bitwise AND with an immediate, a bitwise XOR with an immediate, a full load from a source operand, and a read-out to a destination bus. The operation is presented together with a 16-bit operand and a valid strobe. It takes effect on the next rising clock edge.

All three write operations are privileged. They take effect only while the register's own supervisor bit (bit 13) is set. A write attempted in user mode leaves the register untouched and raises a one-cycle privilege-violation pulse. An operation that completes normally raises a one-cycle pipeline-flush pulse, because it either read or changed the machine status. Unimplemented bit positions are forced to zero on every write.

Top module: `sr_ctrl_unit`

## Requirements
- R1: After reset the status register reads 0x2700, which is supervisor mode with interrupt mask 7. The read-data bus is 0, and neither the flush pulse nor the violation pulse is asserted.
- R2: Operation code 2'b00 (AND) in supervisor mode replaces the register with the bitwise AND of the operand and the current value. The new value is visible on the cycle after the strobe.
- R3: Operation code 2'b01 (XOR) in supervisor mode replaces the register with the bitwise XOR of the operand and the current value.
- R4: Operation code 2'b10 (LOAD) in supervisor mode replaces the register with the operand.
- R5: Operation code 2'b11 (READ) places the current register value on the read-data bus one cycle after the strobe. It leaves the register unchanged. The bus holds that value until the next read or reset.
- R6: Bits 12, 11, 7, 6 and 5 of the register always read 0, whatever value a write supplies. All other bits take the written value.
- R7: Every operation that completes asserts the flush output for exactly the one cycle after its strobe. The flush output stays low on cycles that follow no strobe.
- R8: A write operation (codes 2'b00, 2'b01, 2'b10) strobed while bit 13 of the register is 0 leaves the register unchanged. It asserts the violation output for the one following cycle and does not assert flush.
- R9: A READ strobed in user mode (bit 13 = 0) is carried out normally. It updates the read-data bus, asserts flush and does not assert the violation output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe, one operation per cycle it is high |
| op_i | input | 2 | Operation: 00 AND, 01 XOR, 10 LOAD, 11 READ |
| operand_i | input | 16 | Immediate or source operand |
| sr_o | output | 16 | Current status register value |
| rd_data_o | output | 16 | Value captured by the last READ |
| priv_viol_o | output | 1 | One-cycle pulse on a write refused in user mode |
| flush_o | output | 1 | One-cycle pipeline-flush request |

## Verification
The hardest state to reach is user mode. Only reset can leave it, so once the bench enters user mode it cannot get back out through the ports. The stimulus therefore runs the full table of supervisor-mode writes and reads first. It then uses an AND with bit 13 cleared to drop into user mode, applies every write code there to confirm each is refused, and applies a READ to show it still works. A final mid-run reset confirms the way back to supervisor mode.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    SR_OP_AND  = 2'b00,
    SR_OP_XOR  = 2'b01,
    SR_OP_LOAD = 2'b10,
    SR_OP_READ = 2'b11
  } sr_op_e;

  function automatic logic op_writes(input sr_op_e op);
    return op != SR_OP_READ;
  endfunction
endpackage

// File: rtl/sr_next_calc.sv
module sr_next_calc
  import sr_pkg::*;
#(
  parameter int             W    = 16,
  parameter logic [W-1:0]   MASK = 16'hE71F
) (
  input  sr_op_e         op,
  input  logic [W-1:0]   operand,
  input  logic [W-1:0]   cur,
  output logic [W-1:0]   next
);
  // Raw result before masking of unimplemented positions
  function automatic logic [W-1:0] combine(input sr_op_e o,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] c);
    case (o)
      SR_OP_AND:  return a & c;
      SR_OP_XOR:  return a ^ c;
      SR_OP_LOAD: return a;
      default:    return c;
    endcase
  endfunction

  function automatic logic [W-1:0] squash(input logic [W-1:0] v);
    return v & MASK;
  endfunction

  assign next = squash(combine(op, operand, cur));
endmodule

// File: rtl/sr_priv_gate.sv
module sr_priv_gate
  import sr_pkg::*;
(
  input  logic   valid,
  input  sr_op_e op,
  input  logic   super_mode,
  output logic   commit_wr,
  output logic   take_read,
  output logic   violation,
  output logic   flush_req
);
  logic wants_write;
  assign wants_write = valid && op_writes(op);
  assign commit_wr   = wants_write && super_mode;
  assign violation   = wants_write && !super_mode;
  assign take_read   = valid && !op_writes(op);
  assign flush_req   = commit_wr || take_read;

  always_comb begin
    assert (!(violation && flush_req)); // R8
  end
endmodule

// File: rtl/sr_ctrl_unit.sv
module sr_ctrl_unit
  import sr_pkg::*;
#(
  parameter int           SR_W      = 16,
  parameter int           SUPER_BIT = 13,
  parameter logic [15:0]  IMPL_MASK = 16'hE71F,
  parameter logic [15:0]  RESET_VAL = 16'h2700
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [SR_W-1:0] operand_i,
  output logic [SR_W-1:0] sr_o,
  output logic [SR_W-1:0] rd_data_o,
  output logic            priv_viol_o,
  output logic            flush_o
);
  localparam logic [SR_W-1:0] MASK_W  = SR_W'(IMPL_MASK);
  localparam logic [SR_W-1:0] RESET_W = SR_W'(RESET_VAL) & MASK_W;

  sr_op_e          op;
  logic [SR_W-1:0] sr_q, sr_next, rd_q;
  logic            commit_wr, take_read, violation, flush_req;
  logic            viol_q, flush_q;

  assign op = sr_op_e'(op_i);

  sr_next_calc #(.W(SR_W), .MASK(MASK_W)) u_calc (
    .op      (op),
    .operand (operand_i),
    .cur     (sr_q),
    .next    (sr_next)
  );

  sr_priv_gate u_gate (
    .valid      (valid_i),
    .op         (op),
    .super_mode (sr_q[SUPER_BIT]),
    .commit_wr  (commit_wr),
    .take_read  (take_read),
    .violation  (violation),
    .flush_req  (flush_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= RESET_W;
      rd_q    <= '0;
      viol_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (commit_wr) sr_q <= sr_next;
      if (take_read) rd_q <= sr_q;
      viol_q  <= violation;
      flush_q <= flush_req;
    end
  end

  assign sr_o        = sr_q;
  assign rd_data_o   = rd_q;
  assign priv_viol_o = viol_q;
  assign flush_o     = flush_q;

  AST_USER_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 2'b11 && !sr_q[SUPER_BIT]) |=> $stable(sr_q)); // R8
  AST_USER_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 2'b11 && !sr_q[SUPER_BIT]) |=> (priv_viol_o && !flush_o)); // R8
  AST_READ_KEEPS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b11) |=> $stable(sr_q)); // R5
  AST_READ_RETURNS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b11) |=> (rd_data_o == $past(sr_q))); // R5
  AST_FLUSH_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !flush_o); // R7
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o & ~MASK_W) == '0); // R6
  AST_USER_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b11) |=> (flush_o && !priv_viol_o)); // R9
endmodule

// File: tb/test_sr_ctrl_unit.sv
module test_sr_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [15:0] operand_i = 16'h0;
  logic [15:0] sr_o, rd_data_o;
  logic        priv_viol_o, flush_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam logic [1:0] AND_C = 2'b00, XOR_C = 2'b01, LOAD_C = 2'b10, READ_C = 2'b11;
  localparam logic [15:0] KEEP = 16'hE71F;

  always #5 clk = ~clk;

  sr_ctrl_unit i_sr_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .sr_o(sr_o), .rd_data_o(rd_data_o),
    .priv_viol_o(priv_viol_o), .flush_o(flush_o)
  );

  // {op, operand, expected sr, expected rd_data}, supervisor mode throughout
  localparam int NV = 9;
  localparam logic [49:0] VEC [NV] = '{
    {READ_C, 16'h0000, 16'h2700, 16'h2700},
    {LOAD_C, 16'hFFFF, 16'hE71F, 16'h2700},
    {XOR_C,  16'h001F, 16'hE700, 16'h2700},
    {AND_C,  16'hFAFF, 16'hE200, 16'h2700},
    {LOAD_C, 16'h3C15, 16'h2415, 16'h2700},
    {READ_C, 16'h0000, 16'h2415, 16'h2415},
    {XOR_C,  16'h18E0, 16'h2415, 16'h2415},
    {XOR_C,  16'h8003, 16'hA416, 16'h2415},
    {READ_C, 16'h0000, 16'hA416, 16'hA416}
  };

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Strobe one operation; outputs are sampled on the following falling edge
  task automatic issue(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; operand_i = d;
    @(negedge clk);
    valid_i = 1'b0; operand_i = 16'h0;
  endtask

  // Independent model of the write result, used for the table expectations
  function automatic logic [15:0] model(input logic [1:0] op, input logic [15:0] d,
                                        input logic [15:0] s);
    logic [15:0] r;
    if (op == AND_C)       r = s & d;
    else if (op == XOR_C)  r = s ^ d;
    else if (op == LOAD_C) r = d;
    else                   r = s;
    return r & KEEP;
  endfunction

  initial begin
    logic [15:0] shadow;
    repeat (2) @(negedge clk);
    check16("R1 reset sr", sr_o, 16'h2700);
    check16("R1 reset rd", rd_data_o, 16'h0000);
    check1("R1 reset flush", flush_o, 1'b0);
    check1("R1 reset viol", priv_viol_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R7 idle no flush", flush_o, 1'b0);

    shadow = 16'h2700;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [15:0] d, esr, erd;
      {op, d, esr, erd} = VEC[i];
      issue(op, d);
      shadow = model(op, d, shadow);
      check16("R2/R3/R4 table model", esr, shadow);
      check16("R2 R3 R4 R6 table sr", sr_o, esr);
      check16("R5 table rd", rd_data_o, erd);
      check1("R7 table flush", flush_o, 1'b1);
      check1("R8 table viol", priv_viol_o, 1'b0);
    end
    @(negedge clk);
    check1("R7 flush one cycle", flush_o, 1'b0);

    // Drop to user mode: clear bit 13
    issue(AND_C, 16'hDFFF);
    check16("R2 enter user", sr_o, 16'h8416);
    check1("R7 enter user flush", flush_o, 1'b1);

    issue(LOAD_C, 16'hFFFF);
    check16("R8 user load held", sr_o, 16'h8416);
    check1("R8 user load viol", priv_viol_o, 1'b1);
    check1("R8 user load no flush", flush_o, 1'b0);
    issue(XOR_C, 16'h2000);
    check16("R8 user xor held", sr_o, 16'h8416);
    check1("R8 user xor viol", priv_viol_o, 1'b1);
    issue(AND_C, 16'h0000);
    check16("R8 user and held", sr_o, 16'h8416);
    check1("R8 user and no flush", flush_o, 1'b0);
    @(negedge clk);
    check1("R8 viol one cycle", priv_viol_o, 1'b0);

    issue(READ_C, 16'h0000);
    check16("R9 user read rd", rd_data_o, 16'h8416);
    check1("R9 user read flush", flush_o, 1'b1);
    check1("R9 user read viol", priv_viol_o, 1'b0);

    // Reset mid-run restores supervisor mode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check16("R1 re-reset sr", sr_o, 16'h2700);
    check16("R1 re-reset rd", rd_data_o, 16'h0000);
    rst_n = 1'b1;
    issue(LOAD_C, 16'hFFFF);
    check16("R6 load all ones", sr_o, 16'hE71F);
    issue(LOAD_C, 16'h18E0);
    check16("R6 unimplemented only", sr_o, 16'h0000);
    check1("R7 last flush", flush_o, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule